// File: doc/BRIEF.md
# Threshold-Driven Audio Sample FIFO

This block is a word-organised sample buffer that sits between a bus-side DMA engine and a serial audio shifter. The same RTL serves both directions, and a parameter chooses which one. In the transmit build, the DMA engine fills the buffer and the shifter drains it. In the receive build, the shifter fills it and the DMA engine drains it. Capacity is counted in words, not bytes. A 16-bit or a 32-bit sample therefore takes one location either way, so the byte capacity doubles at 32-bit samples while the word capacity stays the same. Typical depths are 128 words, or 1280 words for a large instance.

The block does not raise a request for every word. It asserts `dma_req` while a programmable word threshold is met. The transmit build needs at least that many free locations. The receive build needs at least that many stored words. Software normally programs the threshold to the DMA packet size, or, when no packet size is in use, to the period length in words (period bytes divided by bytes per word). When threshold mode is off, the threshold behaves as 1 and the request follows single elements. The fill level is also reported as whole audio frames, meaning the occupancy divided by the active channel count with any remainder dropped, so that software can estimate latency.

Occupancy is tracked by a small state machine with three states: `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`. Its transitions are:
- `OCC_EMPTY` to `OCC_PART` on an accepted write.
- `OCC_PART` to `OCC_FULL` when an accepted write brings the count to the depth.
- `OCC_FULL` to `OCC_PART` on an accepted read.
- `OCC_PART` to `OCC_EMPTY` when an accepted read leaves no words.
- `OCC_PART` stays in `OCC_PART` otherwise.
- With a depth of one, `OCC_EMPTY` and `OCC_FULL` switch directly.

Top module: `audio_thr_fifo`

## Requirements
- R1: After reset, `fill_cnt` and `frame_delay` are 0, both sticky flags are 0, and the stored threshold is 1. The receive build therefore drives `dma_req` low and the transmit build drives it high.
- R2: Words are read in the order they were written. `rd_data` always presents the oldest stored word. `fill_cnt` goes up by one on each accepted write and down by one on each accepted read.
- R3: A write while `fill_cnt` equals DEPTH is dropped. The contents and count stay unchanged, and `ovf_flag` is set.
- R4: A read while `fill_cnt` is 0 is dropped. The count stays 0, and `udf_flag` is set.
- R5: A write and a read in the same cycle, with the buffer neither empty nor full, both take effect and leave `fill_cnt` unchanged. A write and a read together on a full buffer accept the read and drop the write.
- R6: A threshold write stores its value when it lies in 1..DEPTH. A value of 0 is stored as 1, and a value above DEPTH is stored as DEPTH.
- R7: With `thr_mode` = 0, the effective threshold is 1 regardless of the stored value. With `thr_mode` = 1, it is the stored value.
- R8: Transmit build (IS_TX = 1): `dma_req` is high exactly when DEPTH minus `fill_cnt` is at least the effective threshold.
- R9: Receive build (IS_TX = 0): `dma_req` is high exactly when `fill_cnt` is at least the effective threshold.
- R10: `frame_delay` equals `fill_cnt` divided by `chan_cnt`, rounded down. A `chan_cnt` of 0 is treated as 1.
- R11: `ovf_flag` and `udf_flag` stay set until reset.
- R12: `fill_cnt`, `frame_delay` and `dma_req` reflect an accepted access or a threshold write after the same clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe; removes the oldest word |
| rd_data | output | DATA_W | Oldest stored word (show-ahead) |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wdata | input | CNT_W+1 | Threshold value to write |
| thr_mode | input | 1 | 1: threshold mode; 0: effective threshold 1 |
| chan_cnt | input | CH_W | Active channel count (0 treated as 1) |
| dma_req | output | 1 | DMA request level |
| fill_cnt | output | CNT_W | Occupied word locations |
| frame_delay | output | CNT_W | Occupied locations in whole frames |
| ovf_flag | output | 1 | Sticky: write refused while full |
| udf_flag | output | 1 | Sticky: read refused while empty |

## Verification
The assertions check several things on every cycle:
- `fill_cnt` never exceeds the depth.
- A lone write to a full buffer keeps the count and raises the overflow flag, and a lone read of an empty buffer does the same for underflow.
- Both flags stay set once raised.
- A simultaneous read and write on a partially filled buffer keeps the count.
- `frame_delay` always lies in the bracket implied by `fill_cnt` and `chan_cnt`.
- With threshold mode off, the request follows the empty and full boundaries.

Some behaviour can only be shown by the bench's scenarios, because it needs history that no single-cycle relation captures:
- word ordering through pointer wrap;
- clamping of out-of-range threshold writes, seen through the request level;
- the exact threshold boundary in each direction.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    // Occupancy state of the sample buffer
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/afifo_store.sv
// Word storage with wrapping read and write pointers (any depth, not only powers of two).
module afifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/afifo_thresh.sv
// Threshold register with clamping and the direction-dependent request compare.
module afifo_thresh #(
    parameter int DEPTH = 128,
    parameter bit IS_TX = 1'b1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [CNT_W:0]   thr_wdata,
    input  logic             thr_mode,
    input  logic [CNT_W-1:0] fill,
    output logic             req
);
    localparam int THR_W = CNT_W + 1;

    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] eff_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= CNT_W'(1);
        end else if (thr_we) begin
            if (thr_wdata == '0) begin
                thr_q <= CNT_W'(1);
            end else if (thr_wdata > THR_W'(DEPTH)) begin
                thr_q <= CNT_W'(DEPTH);
            end else begin
                thr_q <= thr_wdata[CNT_W-1:0];
            end
        end
    end

    assign eff_thr = thr_mode ? thr_q : CNT_W'(1);

    generate
        if (IS_TX) begin : g_tx
            logic [CNT_W-1:0] free_w;
            assign free_w = CNT_W'(DEPTH) - fill;
            assign req    = (free_w >= eff_thr);
        end else begin : g_rx
            assign req = (fill >= eff_thr);
        end
    endgenerate

endmodule

// File: rtl/afifo_frames.sv
// Occupancy expressed in whole frames: fill / channels, remainder dropped.
module afifo_frames #(
    parameter int CNT_W = 8,
    parameter int CH_W  = 5
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [CH_W-1:0]  chan,
    output logic [CNT_W-1:0] frames
);
    localparam int W = (CNT_W > CH_W) ? CNT_W : CH_W;

    logic [W-1:0] num, den, quo;

    always_comb begin
        num    = W'(fill);
        den    = (chan == '0) ? W'(1) : W'(chan);
        quo    = num / den;
        frames = CNT_W'(quo);
    end

endmodule

// File: rtl/audio_thr_fifo.sv
module audio_thr_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    parameter int CH_W   = 5,
    parameter bit IS_TX  = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              thr_we,
    input  logic [CNT_W:0]    thr_wdata,
    input  logic              thr_mode,
    input  logic [CH_W-1:0]   chan_cnt,
    output logic              dma_req,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic [CNT_W-1:0]  frame_delay,
    output logic              ovf_flag,
    output logic              udf_flag
);
    import afifo_pkg::*;

    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             push, pop;

    // Acceptance depends only on the registered occupancy state
    always_comb begin
        push  = wr_en && (state_q != OCC_FULL);
        pop   = rd_en && (state_q != OCC_EMPTY);
        cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
        unique case (state_q)
            OCC_EMPTY: state_d = push ? ((cnt_d == CNT_W'(DEPTH)) ? OCC_FULL : OCC_PART) : OCC_EMPTY;
            OCC_PART: begin
                if (cnt_d == '0) begin
                    state_d = OCC_EMPTY;
                end else if (cnt_d == CNT_W'(DEPTH)) begin
                    state_d = OCC_FULL;
                end else begin
                    state_d = OCC_PART;
                end
            end
            OCC_FULL:  state_d = pop ? ((cnt_d == '0) ? OCC_EMPTY : OCC_PART) : OCC_FULL;
            default:   state_d = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Sticky error outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
        end else begin
            if (wr_en && (state_q == OCC_FULL)) begin
                ovf_flag <= 1'b1;
            end
            if (rd_en && (state_q == OCC_EMPTY)) begin
                udf_flag <= 1'b1;
            end
        end
    end

    assign fill_cnt = cnt_q;

    afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    afifo_thresh #(.DEPTH(DEPTH), .IS_TX(IS_TX), .CNT_W(CNT_W)) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .thr_mode  (thr_mode),
        .fill      (cnt_q),
        .req       (dma_req)
    );

    afifo_frames #(.CNT_W(CNT_W), .CH_W(CH_W)) u_frames (
        .fill   (cnt_q),
        .chan   (chan_cnt),
        .frames (frame_delay)
    );

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int DEPTH = 128,
    parameter int CH_W  = 5,
    parameter bit IS_TX = 1'b1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             thr_mode,
    input logic [CH_W-1:0]  chan_cnt,
    input logic             dma_req,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [CNT_W-1:0] frame_delay,
    input logic             ovf_flag,
    input logic             udf_flag
);
    int ce, fd, fc;
    always_comb begin
        ce = (chan_cnt == '0) ? 1 : int'(chan_cnt);
        fd = int'(frame_delay);
        fc = int'(fill_cnt);
    end

    // R2 / R3: occupancy never exceeds the depth
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CNT_W'(DEPTH) && wr_en && !rd_en) |=> (fill_cnt == CNT_W'(DEPTH) && ovf_flag));

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0 && rd_en && !wr_en) |=> (fill_cnt == '0 && udf_flag));

    a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && fill_cnt != '0 && fill_cnt != CNT_W'(DEPTH)) |=> $stable(fill_cnt));

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r11_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        udf_flag |=> udf_flag);

    a_r10_frame_bracket: assert property (@(posedge clk) disable iff (!rst_n)
        (fd * ce <= fc) && (fc < (fd + 1) * ce));

    generate
        if (IS_TX) begin : g_tx
            a_r7_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
                !thr_mode |-> (dma_req == (fill_cnt != CNT_W'(DEPTH))));
        end else begin : g_rx
            a_r7_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
                !thr_mode |-> (dma_req == (fill_cnt != '0)));
        end
    endgenerate

endmodule

bind audio_thr_fifo afifo_chk #(.DEPTH(DEPTH), .CH_W(CH_W), .IS_TX(IS_TX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .thr_mode    (thr_mode),
    .chan_cnt    (chan_cnt),
    .dma_req     (dma_req),
    .fill_cnt    (fill_cnt),
    .frame_delay (frame_delay),
    .ovf_flag    (ovf_flag),
    .udf_flag    (udf_flag)
);

// File: tb/audio_thr_fifo_tb.sv
module audio_thr_fifo_tb;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int DEP   = 8;
    localparam int CW    = 5;
    localparam int NW    = $clog2(DEP + 1);

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [7:0]    data;
        logic [4:0]    chan;
        logic [3:0]    exp_fill;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hA1, 5'd2, 4'd1},
        '{1'b1, 1'b0, 8'hA2, 5'd2, 4'd2},
        '{1'b1, 1'b0, 8'hA3, 5'd2, 4'd3},
        '{1'b1, 1'b0, 8'hA4, 5'd3, 4'd4},
        '{1'b1, 1'b1, 8'hA5, 5'd3, 4'd4},
        '{1'b1, 1'b0, 8'hA6, 5'd1, 4'd5},
        '{1'b0, 1'b1, 8'h00, 5'd2, 4'd4},
        '{1'b1, 1'b0, 8'hA7, 5'd4, 4'd5},
        '{1'b1, 1'b0, 8'hA8, 5'd0, 4'd6},
        '{1'b1, 1'b0, 8'hA9, 5'd3, 4'd7},
        '{1'b1, 1'b0, 8'hAA, 5'd3, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0, thr_we = 1'b0, thr_mode = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [NW:0]   thr_wdata = '0;
    logic [CW-1:0] chan_cnt = 5'd1;

    logic [DW-1:0] rx_rd_data, tx_rd_data;
    logic          rx_req, tx_req, rx_ovf, rx_udf, tx_ovf, tx_udf;
    logic [NW-1:0] rx_fill, rx_delay, tx_fill, tx_delay;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model
    int m_cnt = 0, m_thr = 1, m_head = 0, m_tail = 0;
    bit m_mode = 1'b1, m_ovf = 1'b0, m_udf = 1'b0;
    int m_q [DEP];

    always #(CLK_P / 2) clk = ~clk;

    audio_thr_fifo #(.DATA_W(DW), .DEPTH(DEP), .CH_W(CW), .IS_TX(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rx_rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_mode(thr_mode),
        .chan_cnt(chan_cnt), .dma_req(rx_req), .fill_cnt(rx_fill), .frame_delay(rx_delay),
        .ovf_flag(rx_ovf), .udf_flag(rx_udf)
    );

    audio_thr_fifo #(.DATA_W(DW), .DEPTH(DEP), .CH_W(CW), .IS_TX(1'b1)) u_dut_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(tx_rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata), .thr_mode(thr_mode),
        .chan_cnt(chan_cnt), .dma_req(tx_req), .fill_cnt(tx_fill), .frame_delay(tx_delay),
        .ovf_flag(tx_ovf), .udf_flag(tx_udf)
    );

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        int ce;
        int eff;
        ce  = (m_chan() == 0) ? 1 : m_chan();
        eff = m_mode ? m_thr : 1;
        check(int'(rx_fill), m_cnt, {tag, " fill"});
        check(int'(tx_fill), m_cnt, {tag, " fill tx"});
        check(int'(rx_delay), m_cnt / ce, "R10 frame_delay");
        check(int'(rx_req), (m_cnt >= eff) ? 1 : 0, {tag, " R9 rx dma_req"});
        check(int'(tx_req), ((DEP - m_cnt) >= eff) ? 1 : 0, {tag, " R8 tx dma_req"});
        check(int'(rx_ovf), int'(m_ovf), {tag, " R3 R11 ovf_flag"});
        check(int'(rx_udf), int'(m_udf), {tag, " R4 R11 udf_flag"});
    endtask

    function automatic int m_chan();
        return int'(chan_cnt);
    endfunction

    // One clock: drive at the falling edge, update model, sample at the next falling edge (R12)
    task automatic cycle(input bit wr, input int data, input bit rd,
                         input bit twe, input int tval, input string tag);
        bit push, pop;
        wr_en     = wr;
        wr_data   = DW'(data);
        rd_en     = rd;
        thr_we    = twe;
        thr_wdata = (NW + 1)'(tval);
        push = wr && (m_cnt < DEP);
        pop  = rd && (m_cnt > 0);
        if (pop) begin
            check(int'(rx_rd_data), m_q[m_head], "R2 rd_data order");
        end
        @(posedge clk);
        if (wr && !push) m_ovf = 1'b1;
        if (rd && !pop)  m_udf = 1'b1;
        if (pop) begin
            m_head = (m_head + 1) % DEP;
            m_cnt--;
        end
        if (push) begin
            m_q[m_tail] = data;
            m_tail = (m_tail + 1) % DEP;
            m_cnt++;
        end
        if (twe) m_thr = (tval == 0) ? 1 : ((tval > DEP) ? DEP : tval);
        @(negedge clk);
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        thr_we = 1'b0;
        check_outputs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_cnt = 0; m_thr = 1; m_head = 0; m_tail = 0; m_ovf = 1'b0; m_udf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check_outputs("R1");
        check(int'(rx_req), 0, "R1 rx dma_req after reset");
        check(int'(tx_req), 1, "R1 tx dma_req after reset");

        // R4: read of an empty buffer
        cycle(1'b0, 0, 1'b1, 1'b0, 0, "R4");
        check(int'(rx_udf), 1, "R4 udf_flag set");

        // R6: in-range threshold stored as written
        cycle(1'b0, 0, 1'b0, 1'b1, 3, "R6");

        // R2 / R5 / R10: table walk
        for (int i = 0; i < NV; i++) begin
            chan_cnt = VECS[i].chan;
            cycle(VECS[i].wr, int'(VECS[i].data), VECS[i].rd, 1'b0, 0,
                  (VECS[i].wr && VECS[i].rd) ? "R5" : "R2");
            check(int'(rx_fill), int'(VECS[i].exp_fill), "R2 R5 table fill");
        end

        // R3: write while full is dropped
        chan_cnt = 5'd1;
        cycle(1'b1, 8'hEE, 1'b0, 1'b0, 0, "R3");
        check(int'(rx_ovf), 1, "R3 ovf_flag set");
        // R5: write and read together on a full buffer: read wins
        cycle(1'b1, 8'hEF, 1'b1, 1'b0, 0, "R5");
        cycle(1'b1, 8'hB0, 1'b0, 1'b0, 0, "R2");

        // R6: clamping of threshold writes
        cycle(1'b0, 0, 1'b0, 1'b1, 20, "R6");
        check(int'(rx_req), 1, "R6 clamp to depth, rx at full");
        cycle(1'b0, 0, 1'b1, 1'b0, 0, "R6");
        check(int'(rx_req), 0, "R6 clamp to depth, rx below full");
        cycle(1'b0, 0, 1'b0, 1'b1, 0, "R6");
        check(int'(rx_req), 1, "R6 zero stored as one");

        // R7: threshold mode off
        thr_mode = 1'b0; m_mode = 1'b0;
        cycle(1'b0, 0, 1'b0, 1'b1, 8, "R7");
        check(int'(tx_req), 1, "R7 tx single-element request");
        for (int k = 0; k < 7; k++) cycle(1'b0, 0, 1'b1, 1'b0, 0, "R7");
        check(int'(rx_req), 0, "R7 rx idle when empty");
        for (int k = 0; k < 8; k++) cycle(1'b1, 8'hC0 + k, 1'b0, 1'b0, 0, "R7");
        check(int'(tx_req), 0, "R7 tx idle when full");

        // R8 / R9: threshold boundary with mode on, thr = 5
        thr_mode = 1'b1; m_mode = 1'b1;
        cycle(1'b0, 0, 1'b0, 1'b1, 5, "R9");
        for (int k = 0; k < 4; k++) cycle(1'b0, 0, 1'b1, 1'b0, 0, "R8");
        check(int'(tx_req), 0, "R8 tx with free 4 below 5");
        cycle(1'b0, 0, 1'b1, 1'b0, 0, "R8");
        check(int'(tx_req), 1, "R8 tx with free 5");
        check(int'(rx_req), 0, "R9 rx with 3 stored below 5");

        // R11: flags persist, then R1 after a fresh reset
        check(int'(rx_ovf) & int'(rx_udf), 1, "R11 both flags still set");
        do_reset();
        check_outputs("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule